// File: doc/BRIEF.md
# Touch-Panel ADC Scan Sequencer

This block runs a complete scan of an eight-input, 12-bit touch-panel converter over a four-wire serial link in SPI mode 0. A one-cycle start pulse latches an enable mask, a per-channel settling count, a per-channel oversampling count, a reference-select bit and an SCLK divider. The block then walks the enabled channels from low address to high. Each channel gets one unbroken run of 24-bit frames, and chip select stays low for the whole scan.

Each frame sends an 8-bit command and clocks in a 16-bit response. The leading settling responses of a run are dropped. The rest are summed and divided with rounding up. Every frame except the last in a run keeps the converter powered. The last frame turns power off, so the device goes back to auto power-down and re-arms its pen-detect output.

When the scan ends, all eight 12-bit results update together in the same cycle as a one-cycle done pulse. A start that arrives with an all-zero mask finishes at once and sends no frames.

Top module: `tadc_scan_seq`

## Requirements
- R1: After reset, chip select is high, SCLK is low, done and busy are low, and all results are zero.
- R2: A frame is 24 SCLK pulses. SCLK idles low. MOSI changes only while SCLK is low and is stable across each high phase. MISO is sampled at the rising edge. The command byte goes out MSB first, followed by 16 zero bits. Chip select stays low from the first frame to the end of the scan, and SCLK pulses only while chip select is low.
- R3: The command byte is built as follows. Bit 7 is 1. Bits 6:4 are the channel address. Bit 3 is 0. Bit 2 is 1 for addresses 0, 2, 6 and 7 and 0 for all others. On every frame but the last of a run, bit 1 equals bit 2 AND the reference-select bit, and bit 0 is 1. On the last frame of a run, bits 1:0 are 00.
- R4: The 12-bit sample is bits 14:3 of the 16 response bits, which arrive MSB first after the command byte. Response bits 15 and 2:0 are ignored.
- R5: A channel's run has skip + ovs frames, where an ovs value of 0 counts as 1. The first skip responses are discarded. The result is ceil(sum of remaining samples / ovs).
- R6: Enabled channels are scanned in ascending address order with no frames for disabled channels. A disabled channel's result reads 0 after the scan.
- R7: The result array changes only in the cycle where done is high. Done is high for exactly one cycle per scan.
- R8: A start pulse while busy has no effect: the scan in progress keeps its latched configuration, and no further scan follows it.
- R9: With an all-zero mask, done is high in the cycle after the start edge, all results are 0, and chip select never falls.
- R10: Each SCLK half-period lasts clk_div_i + 1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan request pulse |
| ch_en_i | input | 8 | Channel enable mask, bit n = address n |
| skip_i | input | 8*SKIP_W | Settling frames per channel, field n at [n*SKIP_W +: SKIP_W] |
| ovs_i | input | 8*OVS_W | Averaged frames per channel, field n at [n*OVS_W +: OVS_W] |
| int_ref_i | input | 1 | Selects the on-chip reference |
| clk_div_i | input | DIV_W | SCLK half-period minus one, in clock cycles |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle scan completion strobe |
| result_o | output | 8*12 | Averaged results, channel n at [n*12 +: 12] |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the converter |
| spi_miso_i | input | 1 | Serial data from the converter |

## Verification
On every cycle, the assertions check the SCLK and chip-select relationship, MOSI stability while SCLK is high, the hold-off of results outside the done cycle, the rejection of a start while busy, the empty-mask shortcut, and the floor identity of the divider, which turns into a ceiling once the bias is added. Some properties can only be shown by the bench's scenarios, because they need a responding converter model: the exact command byte for each frame, extraction of the sample field while the neighbouring response bits carry random values, discarding of settling responses, the rounded-up averages, ascending channel order and the SCLK half-period length.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int ADDR_W     = 3;
  localparam int N_CH       = 1 << ADDR_W;
  localparam int DATA_W     = 12;
  localparam int DATA_LSB   = 3;
  localparam int CMD_W      = 8;
  localparam int RESP_W     = 16;
  localparam int FRAME_BITS = CMD_W + RESP_W;

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_SEND, S_WAIT, S_DGO, S_DWAIT, S_FIN
  } seq_st_e;

  function automatic logic single_ended(input logic [ADDR_W-1:0] addr);
    return (addr == 3'd0) || (addr == 3'd2) || (addr == 3'd6) || (addr == 3'd7);
  endfunction

  // {start, addr, 12-bit mode, ser, ref_on, adc_on}
  function automatic logic [CMD_W-1:0] mk_cmd(input logic [ADDR_W-1:0] addr,
                                              input logic int_ref,
                                              input logic last);
    logic se;
    se = single_ended(addr);
    return {1'b1, addr, 1'b0, se, se & int_ref & ~last, ~last};
  endfunction
endpackage

// File: rtl/tadc_spi_frame.sv
module tadc_spi_frame import tadc_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int RX_W  = DATA_W + DATA_LSB;

  logic                  act_q, sclk_q, done_q;
  logic [DIV_W-1:0]      hc_q;
  logic [BIT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [RX_W-1:0]       rx_q;
  logic                  tick;

  assign tick = act_q && (hc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      hc_q   <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !act_q) begin
        act_q  <= 1'b1;
        sclk_q <= 1'b0;
        hc_q   <= '0;
        bit_q  <= '0;
        tx_q   <= {cmd_i, {RESP_W{1'b0}}};
      end else if (act_q) begin
        if (tick) begin
          hc_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[RX_W-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= tx_q << 1;
            end
          end
        end else begin
          hc_q <= hc_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = act_q & tx_q[FRAME_BITS-1];
  assign done_o = done_q;
  assign data_o = rx_q[RX_W-1:DATA_LSB];

  assert_mosi_stable_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |=> (!sclk_q || $stable(mosi_o)));
  assert_sclk_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sclk_q);
endmodule

// File: rtl/tadc_rdiv.sv
module tadc_rdiv #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 3,
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = $clog2(NUM_W) + 1;
  localparam int PW = NUM_W + DEN_W + 1;

  logic             run_q, done_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] q_q, num_q;
  logic [DEN_W:0]   rem_sh;

  assign rem_sh = {rem_q, q_q[NUM_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      num_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        rem_q <= '0;
        q_q   <= num_i;
        num_q <= num_i;
        den_q <= den_i;
      end else if (run_q) begin
        if (rem_sh >= {1'b0, den_q}) begin
          rem_q <= DEN_W'(rem_sh - {1'b0, den_q});
          q_q   <= {q_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh[DEN_W-1:0];
          q_q   <= {q_q[NUM_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NUM_W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = q_q[OUT_W-1:0];

  // floor identity; the caller's bias of den-1 turns it into round-up
  assert_div_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((PW'(q_q) * PW'(den_q) <= PW'(num_q)) &&
                (PW'(num_q) < (PW'(q_q) + PW'(1)) * PW'(den_q))));
endmodule

// File: rtl/tadc_scan_seq.sv
module tadc_scan_seq import tadc_pkg::*; #(
  parameter int SKIP_W = 3,
  parameter int OVS_W  = 3,
  parameter int DIV_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_CH-1:0]          ch_en_i,
  input  logic [N_CH*SKIP_W-1:0]   skip_i,
  input  logic [N_CH*OVS_W-1:0]    ovs_i,
  input  logic                     int_ref_i,
  input  logic [DIV_W-1:0]         clk_div_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [N_CH*DATA_W-1:0]   result_o,
  output logic                     spi_cs_no,
  output logic                     spi_sclk_o,
  output logic                     spi_mosi_o,
  input  logic                     spi_miso_i
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CNT_W = ((SKIP_W > OVS_W) ? SKIP_W : OVS_W) + 1;
  localparam int SUM_W = DATA_W + OVS_W;
  localparam int NUM_W = SUM_W + 1;

  seq_st_e                st_q;
  logic [ADDR_W-1:0]      ch_q;
  logic [N_CH-1:0]        en_q;
  logic [N_CH*SKIP_W-1:0] skip_q;
  logic [N_CH*OVS_W-1:0]  ovs_q;
  logic                   ref_q;
  logic [DIV_W-1:0]       div_q;
  logic [CNT_W-1:0]       frm_q;
  logic [SUM_W-1:0]       sum_q;
  logic [N_CH*DATA_W-1:0] shadow_q, res_q;
  logic                   done_q, cs_n_q;

  logic [SKIP_W-1:0] skip_cur;
  logic [OVS_W-1:0]  ovs_raw, ovs_eff;
  logic [CNT_W-1:0]  tot;
  logic              last_frm, ch_last;
  logic [CMD_W-1:0]  cmd;
  logic              fr_done, dv_done;
  logic [DATA_W-1:0] fr_data, dv_quo;
  logic [NUM_W-1:0]  dv_num;

  assign skip_cur = skip_q[ch_q*SKIP_W +: SKIP_W];
  assign ovs_raw  = ovs_q[ch_q*OVS_W +: OVS_W];
  assign ovs_eff  = (ovs_raw == '0) ? OVS_W'(1) : ovs_raw;
  assign tot      = CNT_W'(skip_cur) + CNT_W'(ovs_eff);
  assign last_frm = (frm_q == tot - CNT_W'(1));
  assign ch_last  = (ch_q == ADDR_W'(N_CH - 1));
  assign cmd      = mk_cmd(ch_q, ref_q, last_frm);
  assign dv_num   = NUM_W'(sum_q) + NUM_W'(ovs_eff) - NUM_W'(1);

  tadc_spi_frame #(.DIV_W(DIV_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == S_SEND),
    .cmd_i   (cmd),
    .div_i   (div_q),
    .miso_i  (spi_miso_i),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o),
    .done_o  (fr_done),
    .data_o  (fr_data)
  );

  tadc_rdiv #(.NUM_W(NUM_W), .DEN_W(OVS_W), .OUT_W(DATA_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == S_DGO),
    .num_i   (dv_num),
    .den_i   (ovs_eff),
    .done_o  (dv_done),
    .quo_o   (dv_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      ch_q     <= '0;
      en_q     <= '0;
      skip_q   <= '0;
      ovs_q    <= '0;
      ref_q    <= 1'b0;
      div_q    <= '0;
      frm_q    <= '0;
      sum_q    <= '0;
      shadow_q <= '0;
      res_q    <= '0;
      done_q   <= 1'b0;
      cs_n_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          if (ch_en_i == '0) begin
            res_q  <= '0;
            done_q <= 1'b1;
          end else begin
            en_q     <= ch_en_i;
            skip_q   <= skip_i;
            ovs_q    <= ovs_i;
            ref_q    <= int_ref_i;
            div_q    <= clk_div_i;
            ch_q     <= '0;
            shadow_q <= '0;
            cs_n_q   <= 1'b0;
            st_q     <= S_PICK;
          end
        end
        S_PICK: begin
          if (en_q[ch_q]) begin
            frm_q <= '0;
            sum_q <= '0;
            st_q  <= S_SEND;
          end else if (ch_last) begin
            st_q <= S_FIN;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        S_SEND: st_q <= S_WAIT;
        S_WAIT: if (fr_done) begin
          if (frm_q >= CNT_W'(skip_cur)) sum_q <= sum_q + SUM_W'(fr_data);
          if (last_frm) begin
            st_q <= S_DGO;
          end else begin
            frm_q <= frm_q + 1'b1;
            st_q  <= S_SEND;
          end
        end
        S_DGO: st_q <= S_DWAIT;
        S_DWAIT: if (dv_done) begin
          shadow_q[ch_q*DATA_W +: DATA_W] <= dv_quo;
          if (ch_last) begin
            st_q <= S_FIN;
          end else begin
            ch_q <= ch_q + 1'b1;
            st_q <= S_PICK;
          end
        end
        S_FIN: begin
          res_q  <= shadow_q;
          done_q <= 1'b1;
          cs_n_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign spi_cs_no = cs_n_q;

  assert_sclk_in_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !spi_cs_no);
  assert_cs_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && st_q != S_FIN) |-> !spi_cs_no);
  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(en_q) && $stable(skip_q) && $stable(ovs_q)));
  assert_empty_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && ch_en_i == '0) |=> (done_o && spi_cs_no && !busy_o));
endmodule

// File: tb/sim_tadc_scan_seq.sv
module sim_tadc_scan_seq;
  timeunit 1ns; timeprecision 1ps;

  localparam int NC = 8, SW = 3, OW = 3, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          start = 0, int_ref = 0, miso = 0;
  logic [NC-1:0] ch_en = '0;
  logic [NC*SW-1:0] skip = '0;
  logic [NC*OW-1:0] ovs = '0;
  logic [DW-1:0] div = '0;
  logic busy, done, cs_n, sclk, mosi;
  logic [NC*12-1:0] result;

  tadc_scan_seq #(.SKIP_W(SW), .OVS_W(OW), .DIV_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_en_i(ch_en), .skip_i(skip),
    .ovs_i(ovs), .int_ref_i(int_ref), .clk_div_i(div), .busy_o(busy), .done_o(done),
    .result_o(result), .spi_cs_no(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
    .spi_miso_i(miso));

  int nchk = 0, nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model
  logic [11:0] frm_val [0:255];
  logic [7:0]  cmd_log [0:255];
  logic [7:0]  cmd_sh;
  logic [15:0] word;
  int bitcnt = 0, fidx = 0, cs_falls = 0, nrise = 0, mosi_bad = 0;
  int rise_c [0:1];

  always @(negedge cs_n) begin
    bitcnt = 0; cs_falls++; miso = 1'b0;
  end
  always @(posedge sclk) begin
    cmd_sh = {cmd_sh[6:0], mosi};
    if (bitcnt >= 8 && mosi !== 1'b0) mosi_bad++;
    if (nrise < 2) rise_c[nrise] = cyc;
    nrise++;
    bitcnt++;
    if (bitcnt == 8 && fidx < 256) begin
      cmd_log[fidx] = cmd_sh;
      word = {1'($urandom), frm_val[fidx], 3'($urandom)};
    end
    if (bitcnt == 24) begin
      bitcnt = 0; fidx++;
    end
  end
  always @(negedge sclk) begin
    if (bitcnt >= 8 && bitcnt < 24) miso = word[23-bitcnt];
    else miso = 1'b0;
  end

  function automatic logic [7:0] exp_cmd(input int a, input bit ir, input bit last);
    bit se;
    se = (a == 0) || (a == 2) || (a == 6) || (a == 7);
    return {1'b1, 3'(a), 1'b0, se, se & ir & ~last, ~last};
  endfunction

  task automatic run_scan(input logic [NC-1:0] m, input logic [NC*SW-1:0] sk,
                          input logic [NC*OW-1:0] ov, input bit ir, input int dv,
                          input bit poke);
    logic [NC*12-1:0] prev;
    int waited, idx;
    for (int i = 0; i < 256; i++) frm_val[i] = 12'($urandom);
    fidx = 0; cs_falls = 0; nrise = 0; mosi_bad = 0;
    @(negedge clk);
    ch_en = m; skip = sk; ovs = ov; int_ref = ir; div = DW'(dv); start = 1'b1;
    prev = result;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy === 1'b1, "R8", "busy mid-scan", busy, 1);
      chk(result === prev, "R7", "results held mid-scan", (result !== prev), 0);
      ch_en = 8'hFF; skip = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done !== 1'b1 && waited < 60000) begin
      @(negedge clk); waited++;
    end
    chk(done === 1'b1, "R7", "done seen", done, 1);
    if (m == '0) begin
      chk(waited == 0, "R9", "cycles to done", waited, 0);
      chk(result === '0, "R9", "empty results", (result != 0), 0);
      chk(cs_falls == 0, "R9", "cs falls", cs_falls, 0);
    end else begin
      chk(cs_falls == 1, "R2", "cs falls per scan", cs_falls, 1);
      chk(mosi_bad == 0, "R2", "mosi nonzero after cmd", mosi_bad, 0);
      chk(rise_c[1] - rise_c[0] == 2*(dv+1), "R10", "sclk period cycles",
          rise_c[1] - rise_c[0], 2*(dv+1));
    end
    idx = 0;
    for (int c = 0; c < NC; c++) begin
      if (m[c]) begin
        int s, o, t, sum, ex;
        s = int'(sk[c*SW +: SW]); o = int'(ov[c*OW +: OW]);
        if (o == 0) o = 1;
        t = s + o; sum = 0;
        for (int f = 0; f < t; f++) begin
          chk(cmd_log[idx] === exp_cmd(c, ir, f == t-1), "R3", "command byte",
              cmd_log[idx], exp_cmd(c, ir, f == t-1));
          if (f >= s) sum += int'(frm_val[idx]);
          idx++;
        end
        ex = (sum + o - 1) / o;
        chk(result[c*12 +: 12] == 12'(ex), "R5", $sformatf("avg ch%0d (R4 field)", c),
            result[c*12 +: 12], ex);
      end else begin
        chk(result[c*12 +: 12] == 12'd0, "R6", $sformatf("disabled ch%0d", c),
            result[c*12 +: 12], 0);
      end
    end
    chk(fidx == idx, "R6", "frame count", fidx, idx);
    chk(cs_n === 1'b1, "R2", "cs after done", cs_n, 1);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && fidx == idx, "R8", "no follow-on scan", busy, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1", "cs/sclk in reset", {cs_n, sclk}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R1", "done/busy idle", {done, busy}, 0);
    chk(result === '0, "R1", "results reset", (result != 0), 0);
    // one settling frame, one sample on all channels
    run_scan(8'hFF, {NC{3'd1}}, {NC{3'd1}}, 1'b1, 0, 1'b0);
    run_scan(8'h00, '0, '0, 1'b0, 0, 1'b0);
    run_scan(8'h20, '0, {3'd0, 3'd0, 3'd5, 15'd0}, 1'b0, 1, 1'b0);
    // ovs 0 on ch0 counts as 1, ovs 7 on ch7
    run_scan(8'h81, {NC{3'd3}}, {3'd7, 18'd0, 3'd0}, 1'b1, 3, 1'b0);
    run_scan(8'h0A, {NC{3'd2}}, {NC{3'd3}}, 1'b1, 0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [NC*SW-1:0] rs;
      logic [NC*OW-1:0] ro;
      for (int c = 0; c < NC; c++) begin
        rs[c*SW +: SW] = SW'($urandom % 3);
        ro[c*OW +: OW] = OW'($urandom % 5);
      end
      run_scan(8'($urandom), rs, ro, 1'($urandom), int'($urandom % 2), 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule